// File: doc/BRIEF.md
# Single-Bit ECC Repair Engine

This block decides what to do with one 512-byte block of data after a read. It is given two 24-bit parity codes: the code that was stored next to the data, and the code a generator has just computed over the data as it came back. It forms their syndrome and counts the ones in it. From that count it reports one of three results: the data is clean, a single data bit is wrong and can be repaired, or the damage is beyond repair. When a repair is possible, it works out the byte offset and the bit index of the bad bit. It then fixes that bit in an external page buffer with one read and one write.

A controller loads both codes, pulses `start` and waits for `done`. The result, the offset and the bit index stay on the outputs until the next operation begins. An erased page reads back as all-ones stored code against an all-zeros computed code. That pair is reported as clean rather than as a failure.

Code layout (both inputs use it): bit 2k holds the even parity of level k and bit 2k+1 holds the odd parity of level k, for k = 0..11. Levels 0..2 cover the bit position within a byte. Levels 3..11 cover the byte address.

The controller is a five-state machine:
- IDLE waits for `start`; on `start` it captures the syndrome and goes to SCAN.
- SCAN classifies the syndrome. It goes to FETCH when a repair is needed, otherwise to FINISH.
- FETCH issues the buffer read and always goes to PATCH.
- PATCH writes back the byte with the bad bit flipped and always goes to FINISH.
- FINISH pulses `done` and returns to IDLE.

Top module: `ecc_fix_engine`

## Requirements
- R1: The syndrome is the bitwise XOR of `stored_code` and `computed_code`. Only the syndrome, not the codes themselves, decides the result.
- R2: A syndrome with no bits set gives `status` 2'b00 (clean). The page buffer is neither read nor written.
- R3: A syndrome with exactly 12 bits set gives `status` 2'b01 (repaired), whatever the pattern of those bits.
- R4: For a repair, `bit_idx` is {syn[5], syn[3], syn[1]} (the odd parities of levels 2, 1, 0), most significant first.
- R5: For a repair, `byte_off` is {syn[23], syn[21], ..., syn[9], syn[7]} (the odd parities of levels 11 down to 3), most significant first.
- R6: For a repair, the engine reads the byte at `byte_off` (`buf_rd_en`, with data returned on `buf_rdata` one cycle later). In the next cycle it writes that byte back with bit `bit_idx` inverted. It makes exactly one read and one write.
- R7: A syndrome with exactly one bit set gives `status` 2'b10 (uncorrectable). The buffer is not touched.
- R8: Any other nonzero count (2..11, 13..24) gives `status` 2'b10 and the buffer is not touched, except in the case of R9.
- R9: `stored_code` = 24'hFFFFFF together with `computed_code` = 24'h000000 gives `status` 2'b00, with no buffer access.
- R10: `busy` rises in the cycle after `start` is sampled while idle. `done` is a one-cycle pulse 2 cycles after that edge, or 4 cycles when a repair is made. `busy` falls with the end of `done`.
- R11: `start` asserted while `busy` is high is ignored. The running operation keeps its codes and its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| stored_code | input | 24 | Parity code read back from storage |
| computed_code | input | 24 | Parity code freshly computed over the data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 00 clean, 01 repaired, 10 uncorrectable |
| byte_off | output | 9 | Byte offset of the bad bit |
| bit_idx | output | 3 | Bit index of the bad bit within the byte |
| buf_addr | output | 9 | Page buffer address |
| buf_rd_en | output | 1 | Page buffer read strobe |
| buf_rdata | input | 8 | Page buffer read data, valid one cycle after the read |
| buf_wr_en | output | 1 | Page buffer write strobe |
| buf_wdata | output | 8 | Page buffer write data |

## Verification
The hardest situations to reach are those where the population count alone decides, against intuition. One is a 12-bit syndrome that is not a genuine single-bit pattern; the engine must still repair the address it decodes. The other is the erased pair, whose 24-bit syndrome would otherwise read as uncorrectable. The stimulus table therefore holds hand-built syndromes next to genuine single-bit ones. It places the genuine ones on the two address extremes (offset 0 bit 0, offset 511 bit 7) and on a mixed pattern, each XORed onto a different stored base. A second `start` held high during a repair shows that a clashing request is dropped.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_FETCH,
        ST_PATCH,
        ST_FINISH
    } fix_state_t;

    typedef enum logic [1:0] {
        RES_CLEAN = 2'b00,
        RES_FIXED = 2'b01,
        RES_FATAL = 2'b10
    } fix_result_t;

endpackage

// File: rtl/ecc_popcount.sv
module ecc_popcount #(
    parameter int W     = 24,
    parameter int CNT_W = $clog2(W + 1)
) (
    input  logic [W-1:0]     vec,
    output logic [CNT_W-1:0] count
);
    always_comb begin
        count = '0;
        for (int i = 0; i < W; i++) begin
            count = count + CNT_W'(vec[i]);
        end
    end
endmodule

// File: rtl/ecc_locator.sv
module ecc_locator #(
    parameter int LEVELS = 12,
    parameter int BIT_W  = 3,
    localparam int CODE_W = 2 * LEVELS,
    localparam int OFF_W  = LEVELS - BIT_W
) (
    input  logic [CODE_W-1:0] syn,
    output logic [OFF_W-1:0]  byte_off,
    output logic [BIT_W-1:0]  bit_idx
);
    // odd-parity half of each level pair carries the address bit
    for (genvar j = 0; j < BIT_W; j++) begin : g_bit
        assign bit_idx[j] = syn[2*j + 1];
    end
    for (genvar j = 0; j < OFF_W; j++) begin : g_off
        assign byte_off[j] = syn[2*(j + BIT_W) + 1];
    end
endmodule

// File: rtl/ecc_classifier.sv
module ecc_classifier
    import ecc_fix_pkg::*;
#(
    parameter int LEVELS = 12,
    localparam int CNT_W = $clog2(2 * LEVELS + 1)
) (
    input  logic [CNT_W-1:0] ones,
    input  logic             erased,
    output fix_result_t      result
);
    localparam logic [CNT_W-1:0] FIX_COUNT = CNT_W'(LEVELS);

    always_comb begin
        if (erased || ones == '0) begin
            result = RES_CLEAN;
        end else if (ones == FIX_COUNT) begin
            result = RES_FIXED;
        end else begin
            result = RES_FATAL;
        end
    end
endmodule

// File: rtl/ecc_fix_engine.sv
module ecc_fix_engine
    import ecc_fix_pkg::*;
#(
    parameter int LEVELS = 12,
    parameter int BIT_W  = 3,
    localparam int CODE_W = 2 * LEVELS,
    localparam int OFF_W  = LEVELS - BIT_W,
    localparam int DATA_W = 1 << BIT_W,
    localparam int CNT_W  = $clog2(CODE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CODE_W-1:0] stored_code,
    input  logic [CODE_W-1:0] computed_code,
    output logic              busy,
    output logic              done,
    output logic [1:0]        status,
    output logic [OFF_W-1:0]  byte_off,
    output logic [BIT_W-1:0]  bit_idx,
    output logic [OFF_W-1:0]  buf_addr,
    output logic              buf_rd_en,
    input  logic [DATA_W-1:0] buf_rdata,
    output logic              buf_wr_en,
    output logic [DATA_W-1:0] buf_wdata
);
    fix_state_t        state_q, state_d;
    logic [CODE_W-1:0] syn_q;
    logic              erased_q;
    fix_result_t       result_q;
    logic [OFF_W-1:0]  off_q;
    logic [BIT_W-1:0]  bit_q;

    logic [CNT_W-1:0]  ones;
    fix_result_t       result_c;
    logic [OFF_W-1:0]  off_c;
    logic [BIT_W-1:0]  bit_c;

    ecc_popcount #(.W(CODE_W), .CNT_W(CNT_W)) u_count (
        .vec   (syn_q),
        .count (ones)
    );

    ecc_classifier #(.LEVELS(LEVELS)) u_class (
        .ones   (ones),
        .erased (erased_q),
        .result (result_c)
    );

    ecc_locator #(.LEVELS(LEVELS), .BIT_W(BIT_W)) u_locate (
        .syn      (syn_q),
        .byte_off (off_c),
        .bit_idx  (bit_c)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_SCAN;
            ST_SCAN:   state_d = (result_c == RES_FIXED) ? ST_FETCH : ST_FINISH;
            ST_FETCH:  state_d = ST_PATCH;
            ST_PATCH:  state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and captured operands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            syn_q    <= '0;
            erased_q <= 1'b0;
            result_q <= RES_CLEAN;
            off_q    <= '0;
            bit_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                syn_q    <= stored_code ^ computed_code;
                erased_q <= (&stored_code) && (computed_code == '0);
            end
            if (state_q == ST_SCAN) begin
                result_q <= result_c;
                off_q    <= off_c;
                bit_q    <= bit_c;
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_FINISH);
        buf_rd_en = (state_q == ST_FETCH);
        buf_wr_en = (state_q == ST_PATCH);
        buf_addr  = off_q;
        buf_wdata = buf_rdata ^ (DATA_W'(1) << bit_q);
        status    = result_q;
        byte_off  = off_q;
        bit_idx   = bit_q;
    end
endmodule

// File: rtl/ecc_fix_checker.sv
module ecc_fix_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic [1:0] status,
    input logic       buf_rd_en,
    input logic       buf_wr_en
);
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    assert_launch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_busy_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    assert_write_follows_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en |-> $past(buf_rd_en));

    assert_touch_only_when_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_rd_en || buf_wr_en) |-> status == 2'b01);
endmodule

bind ecc_fix_engine ecc_fix_checker u_fix_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .status    (status),
    .buf_rd_en (buf_rd_en),
    .buf_wr_en (buf_wr_en)
);

// File: tb/tb_ecc_fix_engine.sv
module tb_ecc_fix_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] stored_code = '0;
    logic [23:0] computed_code = '0;
    logic        busy, done;
    logic [1:0]  status;
    logic [8:0]  byte_off, buf_addr;
    logic [2:0]  bit_idx;
    logic        buf_rd_en, buf_wr_en;
    logic [7:0]  buf_rdata = '0;
    logic [7:0]  buf_wdata;
    logic        fill = 1'b0;
    int          rd_cnt = 0, wr_cnt = 0;
    int          checks = 0, fails = 0;

    always #2 clk = ~clk;

    ecc_fix_engine dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .stored_code(stored_code), .computed_code(computed_code),
        .busy(busy), .done(done), .status(status),
        .byte_off(byte_off), .bit_idx(bit_idx),
        .buf_addr(buf_addr), .buf_rd_en(buf_rd_en), .buf_rdata(buf_rdata),
        .buf_wr_en(buf_wr_en), .buf_wdata(buf_wdata)
    );

    // page buffer model with one-cycle read latency
    logic [7:0] mem [0:511];
    always @(posedge clk) begin
        if (fill) begin
            for (int i = 0; i < 512; i++) mem[i] <= 8'(i) ^ 8'h3C;
        end else begin
            if (buf_rd_en) begin
                buf_rdata <= mem[buf_addr];
                rd_cnt    <= rd_cnt + 1;
            end
            if (buf_wr_en) begin
                mem[buf_addr] <= buf_wdata;
                wr_cnt        <= wr_cnt + 1;
            end
        end
    end

    // {stored, computed, status, offset, bit}
    localparam int NV = 13;
    localparam logic [61:0] VECS [0:NV-1] = '{
        {24'hABCDEF, 24'hABCDEF, 2'b00, 9'h000, 3'h0},  // R2 equal codes
        {24'hFFFFFF, 24'h000000, 2'b00, 9'h000, 3'h0},  // R9 erased page
        {24'h123456, 24'h476103, 2'b01, 9'h000, 3'h0},  // R1 syndrome 555555
        {24'h000000, 24'hAAAAAA, 2'b01, 9'h1FF, 3'h7},  // R5 top address
        {24'h0F0F0F, 24'h695695, 2'b01, 9'h0A5, 3'h3},  // R4 mixed address
        {24'h000001, 24'h000000, 2'b10, 9'h000, 3'h0},  // R7 one bit
        {24'h000000, 24'h800000, 2'b10, 9'h000, 3'h0},  // R7 top bit
        {24'h000003, 24'h000000, 2'b10, 9'h000, 3'h0},  // R8 two bits
        {24'h000000, 24'hFFFFFF, 2'b10, 9'h000, 3'h0},  // R8 inverted erased
        {24'h0007FF, 24'h000000, 2'b10, 9'h000, 3'h0},  // R8 eleven bits
        {24'h001FFF, 24'h000000, 2'b10, 9'h000, 3'h0},  // R8 thirteen bits
        {24'hFFF000, 24'h000000, 2'b01, 9'h1F8, 3'h0},  // R3 count-only pattern
        {24'hFFFFFE, 24'h000000, 2'b10, 9'h000, 3'h0}   // R8 near-erased
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic refill();
        @(negedge clk); fill = 1'b1;
        @(negedge clk); fill = 1'b0;
    endtask

    task automatic run_op(input logic [23:0] s, input logic [23:0] c, input bit clash, output int lat);
        @(negedge clk);
        stored_code = s; computed_code = c; start = 1'b1;
        @(negedge clk);
        if (clash) begin
            stored_code = 24'h000001; computed_code = 24'h000000;
        end else begin
            start = 1'b0;
        end
        check(busy == 1'b1, "R10 busy after start", 32'(busy), 32'd1);
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            start = 1'b0;
            lat++;
        end
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int lat;
        int rd0, wr0;
        logic [1:0] es;
        logic [8:0] eo;
        logic [2:0] eb;
        logic [7:0] expb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(busy == 0 && done == 0, "R10 reset busy/done", {busy, done}, 0);
        check(status == 2'b00, "R2 reset status", 32'(status), 0);
        check(!buf_rd_en && !buf_wr_en, "R6 reset strobes", {buf_rd_en, buf_wr_en}, 0);

        for (int v = 0; v < NV; v++) begin
            es = VECS[v][13:12];
            eo = VECS[v][11:3];
            eb = VECS[v][2:0];
            refill();
            rd0 = rd_cnt; wr0 = wr_cnt;
            run_op(VECS[v][61:38], VECS[v][37:14], 1'b0, lat);
            check(status == es, "R1/R2/R3/R7/R8/R9 status", 32'(status), 32'(es));
            check(lat == ((es == 2'b01) ? 4 : 2), "R10 done latency", 32'(lat), (es == 2'b01) ? 4 : 2);
            check(wr_cnt - wr0 == ((es == 2'b01) ? 1 : 0), "R2/R6/R7/R8 write count", 32'(wr_cnt - wr0), (es == 2'b01) ? 1 : 0);
            check(rd_cnt - rd0 == ((es == 2'b01) ? 1 : 0), "R2/R6/R7/R8 read count", 32'(rd_cnt - rd0), (es == 2'b01) ? 1 : 0);
            if (es == 2'b01) begin
                expb = (8'(eo) ^ 8'h3C) ^ (8'd1 << eb);
                check(byte_off == eo, "R5 byte offset", 32'(byte_off), 32'(eo));
                check(bit_idx == eb, "R4 bit index", 32'(bit_idx), 32'(eb));
                check(mem[eo] == expb, "R6 repaired byte", 32'(mem[eo]), 32'(expb));
            end
            @(negedge clk);
            check(!busy && !done, "R10 idle after done", {busy, done}, 0);
        end

        // R11: second start held during a repair is dropped
        refill();
        wr0 = wr_cnt;
        run_op(24'h0F0F0F, 24'h695695, 1'b1, lat);
        check(lat == 4, "R11 latency with clashing start", 32'(lat), 4);
        check(status == 2'b01, "R11 status kept", 32'(status), 1);
        check(byte_off == 9'h0A5 && bit_idx == 3'h3, "R11 address kept", {byte_off, bit_idx}, {9'h0A5, 3'h3});
        check(wr_cnt - wr0 == 1, "R11 single write", 32'(wr_cnt - wr0), 1);
        @(negedge clk);
        check(!busy, "R11 no second operation", 32'(busy), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule